// File: doc/BRIEF.md
# Edge-Triggered Capture Sequencer

This block runs one acquisition of a logic analyzer. A host writes a command code to start or stop a capture, or to hand the sample memory over for reading. While a capture runs, a divider on the 50 MHz block clock raises a sample strobe once every `rate_frac + 1` clocks. The external memory writer stores one probe word on each strobe while the store enable is high.

One probe pin, chosen together with an edge polarity, is watched at every sample. The first qualifying edge marks the trigger and latches the memory write pointer of that sample. From then on a post-trigger counter counts samples. The count is the host's post-trigger byte scaled so that 256 stands for the whole memory depth. When the count runs out, storing ends and the write pointer is latched as the stop position. The host reads both positions and the status byte back to locate the trigger inside the stored record.

Top module: `capture_sequencer`

## Requirements
- R1: While capturing, `sample_en` is high in exactly those cycles whose index j after the start (j = 1 being the first cycle after the start command is registered) is a multiple of `rate_frac + 1`. It is never high while idle.
- R2: Command code 0x0D, presented with `cmd_valid`, starts a capture. From the next cycle `store_en` is 1, the trigger-fired bit and the read enable are clear, and the divider phase restarts.
- R3: `trig_sel[2:0]` picks which of probes 0 to 7 is watched. No other probe has any effect on the trigger.
- R4: `trig_sel[3]` = 0 triggers on a rising edge and 1 on a falling edge, and an edge of the opposite direction is ignored. The pin is compared between consecutive samples, and its level in the start cycle serves as the first reference.
- R5: Only the first qualifying edge of a capture counts. `trig_pos` takes the `wr_ptr` value of the triggering sample cycle, and later edges leave it unchanged.
- R6: Capture ends at the N-th sample after the trigger sample, where N = `post_len` × 2^(DEPTH_LOG2−8). With `post_len` = 0 it ends at the trigger sample itself. `stop_pos` takes `wr_ptr` of that cycle, and `store_en` is 0 from the next cycle.
- R7: `mode_status` holds bit 5 = trigger fired, bit 1 = read enable, bit 0 = storing. All other bits are 0, and bit 5 stays set after the capture ends.
- R8: Command code 0x11 during a capture ends it and latches `wr_ptr` of that cycle into `stop_pos`. The trigger-fired bit keeps its value, so it stays clear if no trigger occurred.
- R9: Command code 0x02 sets the read enable (`mem_read_en` and status bit 1). Any other code has no effect, and a start or a reset clears the read enable.
- R10: After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Qualifies `cmd_code` for one cycle |
| cmd_code | input | 8 | Mode command code |
| trig_sel | input | 4 | [2:0] trigger pin, [3] falling edge |
| rate_frac | input | 8 | Sample divider fraction; rate = clk/(rate_frac+1) |
| post_len | input | 8 | Post-trigger length in 1/256 of memory depth |
| probes | input | PROBES | Probe inputs |
| wr_ptr | input | PTR_W | Current sample memory write pointer |
| sample_en | output | 1 | Sample strobe |
| store_en | output | 1 | Capture in progress, samples are stored |
| mem_read_en | output | 1 | Sample memory handed to the host for reading |
| mode_status | output | 8 | Status byte |
| trig_pos | output | PTR_W | Write pointer latched at the trigger |
| stop_pos | output | PTR_W | Write pointer latched at the end of capture |

## Verification
`sample_en` depends only on registered state, so its expected value is known within the cycle it describes. The divider phase is predicted as a multiple of `rate_frac + 1` counted from the start. A probe level driven in cycle j is seen by the sample of cycle j, so the trigger and stop samples are computed in advance as multiples of the sample period. The fired bit and a cleared `store_en` appear one cycle after those samples. The latched positions are compared against the `wr_ptr` the bench drove in the computed cycles, and every check samples at the falling clock edge after inputs for that cycle were applied.

// File: rtl/capture_sequencer.sv
module capture_sequencer #(
  parameter int PROBES     = 16,
  parameter int PTR_W      = 24,
  parameter int DEPTH_LOG2 = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [7:0]        cmd_code,
  input  logic [3:0]        trig_sel,
  input  logic [7:0]        rate_frac,
  input  logic [7:0]        post_len,
  input  logic [PROBES-1:0] probes,
  input  logic [PTR_W-1:0]  wr_ptr,
  output logic              sample_en,
  output logic              store_en,
  output logic              mem_read_en,
  output logic [7:0]        mode_status,
  output logic [PTR_W-1:0]  trig_pos,
  output logic [PTR_W-1:0]  stop_pos
);
  localparam int SCALE_SH = DEPTH_LOG2 - 8;
  localparam int CNT_W    = DEPTH_LOG2 + 1;
  localparam logic [7:0] CMD_START = 8'h0D;
  localparam logic [7:0] CMD_STOP  = 8'h11;
  localparam logic [7:0] CMD_READ  = 8'h02;

  logic             running, fired, rd_en, prev_pin;
  logic [7:0]       div_cnt;
  logic [CNT_W-1:0] post_cnt, post_limit;

  wire pin_now  = probes[trig_sel[2:0]];
  wire do_start = cmd_valid && (cmd_code == CMD_START);
  wire do_stop  = cmd_valid && (cmd_code == CMD_STOP);
  wire do_read  = cmd_valid && (cmd_code == CMD_READ);

  assign post_limit = {{(CNT_W-8){1'b0}}, post_len} << SCALE_SH;
  assign sample_en  = running && (div_cnt == rate_frac);

  wire edge_hit = sample_en && !fired &&
                  (trig_sel[3] ? (prev_pin && !pin_now) : (!prev_pin && pin_now));
  wire post_end = fired && sample_en && ((post_cnt + CNT_W'(1)) == post_limit);
  wire stop_now = do_stop || (edge_hit && (post_limit == '0)) || post_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running  <= 1'b0;
      fired    <= 1'b0;
      rd_en    <= 1'b0;
      prev_pin <= 1'b0;
      div_cnt  <= '0;
      post_cnt <= '0;
      trig_pos <= '0;
      stop_pos <= '0;
    end else if (do_start) begin
      running  <= 1'b1;
      fired    <= 1'b0;
      rd_en    <= 1'b0;
      div_cnt  <= '0;
      post_cnt <= '0;
      prev_pin <= pin_now;
    end else begin
      if (do_read) rd_en <= 1'b1;
      if (running) begin
        div_cnt <= sample_en ? 8'd0 : div_cnt + 8'd1;
        if (sample_en) prev_pin <= pin_now;
        if (edge_hit) begin
          fired    <= 1'b1;
          trig_pos <= wr_ptr;
          post_cnt <= '0;
        end else if (fired && sample_en) begin
          post_cnt <= post_cnt + CNT_W'(1);
        end
        if (stop_now) begin
          running  <= 1'b0;
          stop_pos <= wr_ptr;
        end
      end
    end
  end

  assign store_en    = running;
  assign mem_read_en = rd_en;
  assign mode_status = {2'b00, fired, 3'b000, rd_en, running};

  p_no_back2back_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && (rate_frac != 8'd0) && !do_start |=> !sample_en || (rate_frac == 8'd0));

  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_start |=> store_en && !mode_status[5] && !mem_read_en);

  p_fire_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mode_status[5] && !do_start |=> mode_status[5] && $stable(trig_pos));

  p_fire_in_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_status[5]) |-> $past(store_en) && $past(sample_en));

  p_stop_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop && store_en |=> !store_en && (stop_pos == $past(wr_ptr)));

  p_idle_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !store_en && !do_start |=> !store_en && $stable(stop_pos));

  p_read_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_read_en && !do_start |=> mem_read_en);
endmodule

// File: tb/capture_sequencer_bench.sv
module capture_sequencer_bench;
  localparam int CLK_NS = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [3:0]  trig_sel = 4'h0;
  logic [7:0]  rate_frac = 8'h00;
  logic [7:0]  post_len = 8'h00;
  logic [15:0] probes = 16'h0000;
  logic [23:0] wr_ptr = 24'h0;
  logic        sample_en, store_en, mem_read_en;
  logic [7:0]  mode_status;
  logic [23:0] trig_pos, stop_pos;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  capture_sequencer u_capture_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .trig_sel(trig_sel), .rate_frac(rate_frac), .post_len(post_len),
    .probes(probes), .wr_ptr(wr_ptr), .sample_en(sample_en),
    .store_en(store_en), .mem_read_en(mem_read_en), .mode_status(mode_status),
    .trig_pos(trig_pos), .stop_pos(stop_pos));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    wr_ptr = 24'(cyc);
  endtask

  task automatic drive(input int pin, input bit lvl);
    logic [15:0] v;
    v = 16'($urandom);
    v[pin] = lvl;
    probes = v;
  endtask

  function automatic int post_samples(input int post);
    return post * 4;
  endfunction

  task automatic run_capture(input int f, input int pin, input bit fall, input int post, input int gap);
    int p, ja, j0, js, jstop;
    bit act, lvl, exp_se;
    logic [23:0] et, es;
    p = f + 1;
    act = !fall;
    ja = 1;
    j0 = ja + p + gap;
    js = ((j0 + p - 1) / p) * p;
    jstop = js + post_samples(post) * p;
    et = '0;
    es = '0;
    rate_frac = 8'(f);
    trig_sel = {fall, 3'(pin)};
    post_len = 8'(post);
    step();
    drive(pin, act);
    cmd_code = 8'h0D;
    cmd_valid = 1'b1;
    for (int j = 1; j <= jstop + 2; j++) begin
      step();
      cmd_valid = 1'b0;
      if (j < ja) lvl = act;
      else if (j < j0) lvl = !act;
      else if (j <= js) lvl = act;
      else lvl = 1'($urandom);
      drive(pin, lvl);
      if (j == js) et = wr_ptr;
      if (j == jstop) es = wr_ptr;
      exp_se = (j <= jstop) && (j % p == 0);
      if (j == 1) chk(store_en && !mode_status[5] && !mem_read_en, "R2 start state", 32'(mode_status), 32'h01);
      chk(sample_en == exp_se, "R1 sample strobe", 32'(sample_en), 32'(exp_se));
      chk(store_en == (j <= jstop), "R6 store enable", 32'(store_en), 32'(j <= jstop));
      chk(mode_status[5] == (j > js), "R7 fired bit", 32'(mode_status[5]), 32'(j > js));
    end
    chk(trig_pos == et, "R3 R4 R5 trigger position", 32'(trig_pos), 32'(et));
    chk(stop_pos == es, "R6 stop position", 32'(stop_pos), 32'(es));
    chk(mode_status == 8'h20, "R7 status after capture", 32'(mode_status), 32'h20);
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    step(); step();
    chk({sample_en, store_en, mem_read_en} == 3'b000 && mode_status == 8'h00 &&
        trig_pos == '0 && stop_pos == '0, "R10 reset outputs", 32'(mode_status), 32'h0);
    rst_n = 1'b1;
    step();

    run_capture(0, 3, 1'b0, 2, 1);
    run_capture(0, 5, 1'b1, 0, 0);
    run_capture(2, 7, 1'b1, 1, 3);
    run_capture(255, 0, 1'b0, 1, 0);
    for (int k = 0; k < 6; k++)
      run_capture(int'($urandom % 6), int'($urandom % 8), 1'($urandom), int'($urandom % 5), int'($urandom % 6));

    // R8: stop before any trigger
    rate_frac = 8'd1;
    trig_sel = 4'b0010;
    post_len = 8'd3;
    step();
    drive(2, 1'b0);
    cmd_code = 8'h0D;
    cmd_valid = 1'b1;
    for (int j = 1; j <= 8; j++) begin
      step();
      cmd_valid = 1'b0;
      drive(2, 1'b0);
      if (j == 5) begin
        cmd_code = 8'h11;
        cmd_valid = 1'b1;
      end
      if (j == 6) chk(stop_pos == 24'(cyc - 1), "R8 stop position", 32'(stop_pos), 32'(cyc - 1));
      if (j >= 6) begin
        chk(!store_en && !sample_en, "R8 capture ended", 32'({store_en, sample_en}), 32'h0);
        chk(mode_status[5] == 1'b0, "R8 fired bit clear", 32'(mode_status), 32'h00);
      end
    end

    // R9: read enable and ignored codes
    cmd_code = 8'h55;
    cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
    chk(mode_status == 8'h00 && !mem_read_en, "R9 ignored code", 32'(mode_status), 32'h00);
    cmd_code = 8'h02;
    cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
    chk(mode_status == 8'h02 && mem_read_en, "R9 read enable", 32'(mode_status), 32'h02);
    cmd_code = 8'hA7;
    cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
    chk(mode_status == 8'h02, "R9 ignored code keeps read", 32'(mode_status), 32'h02);
    cmd_code = 8'h0D;
    cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
    chk(mode_status == 8'h01 && !mem_read_en, "R9 R2 start clears read", 32'(mode_status), 32'h01);
    cmd_code = 8'h11;
    cmd_valid = 1'b1;
    step();
    cmd_valid = 1'b0;
    step();
    chk(mode_status == 8'h00, "R7 status idle", 32'(mode_status), 32'h00);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule